// File: doc/BRIEF.md
# Secure Channel Control Register for a DMA Channel

This block holds the 32-bit configuration word of one DMA channel and hands every decoded field to the channel engine beside it. Software reaches it through a small request/response register bus. Each request carries two attribute bits, secure and privileged. The block applies a per-field policy to every write. That policy depends on those attributes, on the channel's own secure and privileged marks, and on whether the channel is running.

Rejected field updates are dropped quietly. Two kinds of write also raise a one-cycle illegal-access pulse that a nearby security monitor can count: a non-secure write that sets a security bit, and a non-secure write that tries to change the channel-secure mark. Reads are masked so that non-secure software never sees the source or destination security bits.

The request side uses valid/ready. A write completes on its handshake and returns no response. A read completes on its handshake and produces one response beat. That beat is held stable on `rsp_valid`/`rsp_rdata` until `rsp_ready` is seen high, and `req_ready` stays low while an unaccepted beat is pending.

Top module: `sdma_chan_ctl`

## Requirements
- R1: After reset every field is 0. The channel is disabled, direction is from peripheral, both sizes are 8 bits, priority is low, and all mode and interrupt bits are off. `req_ready` is 1, `rsp_valid` is 0, and a read returns 0.
- R2: While the channel is enabled (bit 0 is 1 before the write), a write can change only bit 0. Every other field keeps its value, including during the write that clears bit 0.
- R3: The channel-secure bit (bit 17) changes only on a secure write. A non-secure write whose bit 17 differs from the stored value raises the illegal pulse.
- R4: A non-secure write with a 1 in bit 16 (source secure) or bit 18 (destination secure) leaves those bits unchanged and raises the illegal pulse.
- R5: A non-secure read returns 0 in bits 16 and 18. A secure read returns the stored bits.
- R6: When a secure write that is allowed to update bit 17 leaves it at 0, bits 16 and 18 become 0 whatever values were written.
- R7: The privileged bit (bit 20) changes only on a privileged write.
- R8: When the channel is marked secure, a non-secure write changes no field, including bit 0. When it is marked privileged, a non-privileged write changes no field.
- R9: The illegal pulse is high for exactly the one cycle after the offending write's handshake, and never follows a write that does not offend. Fields that the offending write is allowed to change are still updated.
- R10: Size code 3 is reserved: a write of it leaves that size field unchanged. Bits 15, 19 and 31:21 read as 0 and ignore writes.
- R11: A read response is presented on the cycle after the request handshake. It stays valid with unchanged data until accepted, and `req_ready` is 0 while an unaccepted response is pending.
- R12: Field layout:
  - bit 0: enable
  - bit 1: done-interrupt enable
  - bit 2: half-interrupt enable
  - bit 3: error-interrupt enable
  - bit 4: direction (1 = from memory)
  - bit 5: circular
  - bit 6: peripheral increment
  - bit 7: memory increment
  - bits 9:8: peripheral size
  - bits 11:10: memory size
  - bits 13:12: priority (0 low, 1 medium, 2 high, 3 very high)
  - bit 14: memory-to-memory
  - bit 16: source secure
  - bit 17: channel secure
  - bit 18: destination secure
  - bit 20: privileged
  
  Size codes 0, 1 and 2 mean 8, 16 and 32 bits. Each field drives its own output port, and a write shows on those ports from the cycle after its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access is secure |
| req_priv | input | 1 | Access is privileged |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response sink ready |
| rsp_rdata | output | 32 | Read data, masked for the requester |
| illegal_pulse | output | 1 | One-cycle illegal-access indication |
| chan_en | output | 1 | Channel enabled |
| irq_done_en | output | 1 | Transfer-complete interrupt enable |
| irq_half_en | output | 1 | Half-transfer interrupt enable |
| irq_err_en | output | 1 | Transfer-error interrupt enable |
| dir_from_mem | output | 1 | Source is memory |
| circular | output | 1 | Circular mode |
| periph_inc | output | 1 | Peripheral address increment |
| mem_inc | output | 1 | Memory address increment |
| periph_size | output | 2 | Peripheral transfer size code |
| mem_size | output | 2 | Memory transfer size code |
| prio | output | 2 | Priority level |
| mem2mem | output | 1 | Memory-to-memory mode |
| privileged | output | 1 | Channel is privileged |
| chan_secure | output | 1 | Channel is secure |
| src_secure | output | 1 | Source transfer is secure |
| dst_secure | output | 1 | Destination transfer is secure |

## Verification
The properties take the secure and privileged attributes to belong to the cycle in which `req_valid` and `req_ready` are both high. They assume every request input is a known value from reset onward. They also assume `rsp_ready` may fall at any time, so response holding is checked under true back-pressure.

The stimulus changes inputs only shortly after a rising edge and never drives an unknown value after reset. It holds `rsp_ready` low across several cycles exactly once, to exercise the stall path. It walks the channel through the secure, privileged and enabled marks in turn, so that each protection applies when the offending write arrives.

// File: rtl/sdma_ccr_pkg.sv
package sdma_ccr_pkg;
  localparam int unsigned REG_W = 32;

  // Bit positions that software and the checker depend on.
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_IDONE = 1;
  localparam int unsigned B_IHALF = 2;
  localparam int unsigned B_IERR  = 3;
  localparam int unsigned B_DIR   = 4;
  localparam int unsigned B_CIRC  = 5;
  localparam int unsigned B_PINC  = 6;
  localparam int unsigned B_MINC  = 7;
  localparam int unsigned B_PSZ   = 8;
  localparam int unsigned B_MSZ   = 10;
  localparam int unsigned B_PRIO  = 12;
  localparam int unsigned B_M2M   = 14;
  localparam int unsigned B_SSEC  = 16;
  localparam int unsigned B_CSEC  = 17;
  localparam int unsigned B_DSEC  = 18;
  localparam int unsigned B_PRIV  = 20;

  localparam int unsigned N_FLAGS = 7;

  typedef enum logic [1:0] {
    SZ_8    = 2'b00,
    SZ_16   = 2'b01,
    SZ_32   = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    PRI_LOW  = 2'b00,
    PRI_MED  = 2'b01,
    PRI_HIGH = 2'b10,
    PRI_VHI  = 2'b11
  } prio_e;

  typedef struct packed {
    logic               en;
    logic [N_FLAGS-1:0] flags;  // done, half, err, dir, circ, pinc, minc (bit 1 upward)
    xfer_size_e         psize;
    xfer_size_e         msize;
    prio_e              prio;
    logic               m2m;
    logic               priv;
    logic               csec;
    logic               ssec;
    logic               dsec;
  } ccr_t;

  localparam ccr_t CCR_RESET = '0;

  function automatic ccr_t ccr_unpack(input logic [REG_W-1:0] w);
    ccr_t c;
    c.en    = w[B_EN];
    c.flags = w[B_IDONE +: N_FLAGS];
    c.psize = xfer_size_e'(w[B_PSZ +: 2]);
    c.msize = xfer_size_e'(w[B_MSZ +: 2]);
    c.prio  = prio_e'(w[B_PRIO +: 2]);
    c.m2m   = w[B_M2M];
    c.priv  = w[B_PRIV];
    c.csec  = w[B_CSEC];
    c.ssec  = w[B_SSEC];
    c.dsec  = w[B_DSEC];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ccr_pack(input ccr_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_EN]              = c.en;
    w[B_IDONE +: N_FLAGS] = c.flags;
    w[B_PSZ +: 2]        = c.psize;
    w[B_MSZ +: 2]        = c.msize;
    w[B_PRIO +: 2]       = c.prio;
    w[B_M2M]             = c.m2m;
    w[B_PRIV]            = c.priv;
    w[B_CSEC]            = c.csec;
    w[B_SSEC]            = c.ssec;
    w[B_DSEC]            = c.dsec;
    return w;
  endfunction
endpackage

// File: rtl/sdma_ccr_policy.sv
// Combinational write policy: decides which fields a write may update.
module sdma_ccr_policy
  import sdma_ccr_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  ccr_t         cur,
  input  logic         wr_fire,
  input  logic         acc_sec,
  input  logic         acc_priv,
  input  logic [W-1:0] wdata,
  output ccr_t         nxt,
  output logic         wr_illegal
);
  ccr_t req;
  logic access_ok;
  logic cfg_open;

  always_comb begin
    req = ccr_unpack(wdata);
    // Channel marks gate every field, including enable.
    access_ok = (!cur.csec || acc_sec) && (!cur.priv || acc_priv);
    // Everything but enable is frozen while the channel runs.
    cfg_open  = access_ok && !cur.en;
  end

  always_comb begin
    nxt = cur;
    if (wr_fire) begin
      if (access_ok) nxt.en = req.en;
      if (cfg_open) begin
        nxt.flags = req.flags;
        nxt.prio  = req.prio;
        nxt.m2m   = req.m2m;
        if (req.psize != SZ_RSVD) nxt.psize = req.psize;
        if (req.msize != SZ_RSVD) nxt.msize = req.msize;
        if (acc_priv) nxt.priv = req.priv;
        if (acc_sec) begin
          nxt.csec = req.csec;
          // Dropping the channel to non-secure also drops both transfer marks.
          nxt.ssec = req.csec ? req.ssec : 1'b0;
          nxt.dsec = req.csec ? req.dsec : 1'b0;
        end
      end
    end
  end

  always_comb begin
    wr_illegal = wr_fire && !acc_sec &&
                 (req.ssec || req.dsec || (req.csec != cur.csec));
  end
endmodule

// File: rtl/sdma_ccr_store.sv
// Holds the configuration word and the registered illegal-access pulse.
module sdma_ccr_store
  import sdma_ccr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ccr_t nxt,
  input  logic illegal_d,
  output ccr_t cur,
  output logic illegal_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= CCR_RESET;
      illegal_q <= 1'b0;
    end else begin
      cur       <= nxt;
      illegal_q <= illegal_d;
    end
  end
endmodule

// File: rtl/sdma_ccr_rdport.sv
// Read response stage with back-pressure; masks security bits for non-secure readers.
module sdma_ccr_rdport
  import sdma_ccr_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_fire,
  input  logic         acc_sec,
  input  ccr_t         cur,
  input  logic         rsp_ready,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata,
  output logic         slot_free
);
  ccr_t        view;
  logic [W-1:0] view_w;

  always_comb begin
    view = cur;
    if (!acc_sec) begin
      view.ssec = 1'b0;
      view.dsec = 1'b0;
    end
    view_w = ccr_pack(view);
  end

  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= view_w;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdma_chan_ctl.sv
module sdma_chan_ctl
  import sdma_ccr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_secure,
  input  logic        req_priv,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        illegal_pulse,
  output logic        chan_en,
  output logic        irq_done_en,
  output logic        irq_half_en,
  output logic        irq_err_en,
  output logic        dir_from_mem,
  output logic        circular,
  output logic        periph_inc,
  output logic        mem_inc,
  output logic [1:0]  periph_size,
  output logic [1:0]  mem_size,
  output logic [1:0]  prio,
  output logic        mem2mem,
  output logic        privileged,
  output logic        chan_secure,
  output logic        src_secure,
  output logic        dst_secure
);
  ccr_t cur;
  ccr_t nxt;
  logic wr_illegal;
  logic fire;
  logic wr_fire;
  logic rd_fire;

  assign fire    = req_valid && req_ready;
  assign wr_fire = fire && req_write;
  assign rd_fire = fire && !req_write;

  sdma_ccr_policy #(.W(REG_W)) u_policy (
    .cur       (cur),
    .wr_fire   (wr_fire),
    .acc_sec   (req_secure),
    .acc_priv  (req_priv),
    .wdata     (req_wdata),
    .nxt       (nxt),
    .wr_illegal(wr_illegal)
  );

  sdma_ccr_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt      (nxt),
    .illegal_d(wr_illegal),
    .cur      (cur),
    .illegal_q(illegal_pulse)
  );

  sdma_ccr_rdport #(.W(REG_W)) u_rdport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .acc_sec  (req_secure),
    .cur      (cur),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .slot_free(req_ready)
  );

  assign chan_en      = cur.en;
  assign irq_done_en  = cur.flags[0];
  assign irq_half_en  = cur.flags[1];
  assign irq_err_en   = cur.flags[2];
  assign dir_from_mem = cur.flags[3];
  assign circular     = cur.flags[4];
  assign periph_inc   = cur.flags[5];
  assign mem_inc      = cur.flags[6];
  assign periph_size  = cur.psize;
  assign mem_size     = cur.msize;
  assign prio         = cur.prio;
  assign mem2mem      = cur.m2m;
  assign privileged   = cur.priv;
  assign chan_secure  = cur.csec;
  assign src_secure   = cur.ssec;
  assign dst_secure   = cur.dsec;
endmodule

// File: rtl/sdma_chan_ctl_chk.sv
module sdma_chan_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_secure,
  input logic        req_priv,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        illegal_pulse,
  input logic        chan_en,
  input logic        irq_done_en,
  input logic        irq_half_en,
  input logic        irq_err_en,
  input logic        dir_from_mem,
  input logic        circular,
  input logic        periph_inc,
  input logic        mem_inc,
  input logic [1:0]  periph_size,
  input logic [1:0]  mem_size,
  input logic [1:0]  prio,
  input logic        mem2mem,
  input logic        privileged,
  input logic        chan_secure,
  input logic        src_secure,
  input logic        dst_secure
);
  logic [17:0] frozen;
  logic        wr_hs;
  logic        rd_hs;

  assign frozen = {irq_done_en, irq_half_en, irq_err_en, dir_from_mem, circular,
                   periph_inc, mem_inc, periph_size, mem_size, prio, mem2mem,
                   privileged, chan_secure, src_secure, dst_secure};
  assign wr_hs = req_valid && req_ready && req_write;
  assign rd_hs = req_valid && req_ready && !req_write;

  AST_LOCK_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(frozen)); // R2

  AST_CSEC_NONSEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !req_secure) |=> $stable(chan_secure)); // R3

  AST_SSEC_DSEC_NONSEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !req_secure) |=> ($stable(src_secure) && $stable(dst_secure))); // R4

  AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && !req_secure) |=> (rsp_rdata[16] == 1'b0 && rsp_rdata[18] == 1'b0)); // R5

  AST_SEC_DEPEND: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_secure |-> (!src_secure && !dst_secure)); // R6

  AST_PRIV_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !req_priv) |=> $stable(privileged)); // R7

  AST_SEC_CHAN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !req_secure && chan_secure) |=> ($stable(chan_en) && $stable(frozen))); // R8

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(wr_hs && !req_secure)); // R9

  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_size != 2'b11) && (mem_size != 2'b11)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R11

  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R11
endmodule

bind sdma_chan_ctl sdma_chan_ctl_chk u_chk (.*);

// File: tb/sim_sdma_chan_ctl.sv
`timescale 1ns/1ps
module sim_sdma_chan_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, illegal_pulse;
  logic [31:0] rsp_rdata;
  logic chan_en, irq_done_en, irq_half_en, irq_err_en, dir_from_mem, circular;
  logic periph_inc, mem_inc, mem2mem, privileged, chan_secure, src_secure, dst_secure;
  logic [1:0] periph_size, mem_size, prio;

  always #4 clk = ~clk;

  sdma_chan_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_secure(req_secure), .req_priv(req_priv),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .illegal_pulse(illegal_pulse), .chan_en(chan_en),
    .irq_done_en(irq_done_en), .irq_half_en(irq_half_en), .irq_err_en(irq_err_en),
    .dir_from_mem(dir_from_mem), .circular(circular), .periph_inc(periph_inc),
    .mem_inc(mem_inc), .periph_size(periph_size), .mem_size(mem_size), .prio(prio),
    .mem2mem(mem2mem), .privileged(privileged), .chan_secure(chan_secure),
    .src_secure(src_secure), .dst_secure(dst_secure)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [31:0] m = '0;
  bit          exp_ill = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Output ports arranged into the R12 word layout.
  function automatic logic [31:0] obs();
    return {11'b0, privileged, 1'b0, dst_secure, chan_secure, src_secure, 1'b0, mem2mem,
            prio, mem_size, periph_size, mem_inc, periph_inc, circular, dir_from_mem,
            irq_err_en, irq_half_en, irq_done_en, chan_en};
  endfunction

  // Expected-state model built from R2..R10.
  function automatic void mdl_write(input bit s, input bit p, input logic [31:0] w);
    logic [31:0] n;
    bit ok;
    n  = m;
    ok = (!m[17] || s) && (!m[20] || p);
    exp_ill = !s && (w[16] || w[18] || (w[17] != m[17]));
    if (ok) begin
      n[0] = w[0];
      if (!m[0]) begin
        n[7:1]   = w[7:1];
        n[13:12] = w[13:12];
        n[14]    = w[14];
        if (w[9:8] != 2'b11)   n[9:8]   = w[9:8];
        if (w[11:10] != 2'b11) n[11:10] = w[11:10];
        if (p) n[20] = w[20];
        if (s) begin
          n[17] = w[17];
          n[16] = w[17] ? w[16] : 1'b0;
          n[18] = w[17] ? w[18] : 1'b0;
        end
      end
    end
    m = n;
  endfunction

  task automatic wait_ready();
    while (!req_ready) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input bit s, input bit p, input logic [31:0] w, input string tag);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_secure = s; req_priv = p; req_wdata = w;
    wait_ready();
    @(posedge clk); #1;
    req_valid = 0;
    mdl_write(s, p, w);
    chk(obs() == m, tag, obs(), m);
    chk(illegal_pulse == exp_ill, {tag, " pulse R9"}, {31'b0, illegal_pulse}, {31'b0, exp_ill});
  endtask

  task automatic rd(input bit s, input string tag);
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_secure = s; req_priv = 1;
    wait_ready();
    exp_q.push_back(s ? m : (m & ~32'h0005_0000));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // Monitor: pops the scoreboard on each accepted response beat.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected response", rsp_rdata, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_rdata == e, t, rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk(obs() == 32'h0, "R1 reset fields", obs(), 32'h0);
    chk(req_ready && !rsp_valid && !illegal_pulse, "R1 reset handshake",
        {29'b0, req_ready, rsp_valid, illegal_pulse}, 32'h4);
    rd(1, "R1 reset read");

    wr(1, 1, 32'h0003_36BA, "R12 secure configure");
    rd(0, "R5 non-secure read masked");
    rd(1, "R5 secure read full");

    wr(0, 1, 32'h0000_0001, "R8 R3 non-secure on secure channel");
    @(posedge clk); #1;
    chk(illegal_pulse == 0, "R9 pulse one cycle", {31'b0, illegal_pulse}, 32'h0);

    wr(1, 1, 32'h800B_B7BA, "R10 reserved size and bits");
    rd(1, "R10 reserved read zero");

    wr(1, 0, 32'h0013_76BA, "R7 non-priv sets priv");
    wr(1, 1, 32'h0013_36BA, "R7 priv sets priv");
    wr(1, 0, 32'h0003_0000, "R8 non-priv on priv channel");

    wr(1, 1, 32'h0015_36BA, "R6 clear channel secure");
    wr(0, 1, 32'h0011_16BB, "R4 R9 non-secure ssec partial");
    wr(1, 1, 32'h0013_0001, "R2 locked while enabled");
    wr(1, 1, 32'h0000_0000, "R2 disable keeps fields");
    wr(0, 1, 32'h0010_0000, "R9 clean non-secure write");
    rd(0, "R5 non-secure read after update");

    // R11 back-pressure
    @(posedge clk); #1;
    rsp_ready = 0;
    rd(1, "R11 stalled read data");
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid && !req_ready, "R11 stall holds", {30'b0, rsp_valid, req_ready}, 32'h2);
    rsp_ready = 1;
    rd(0, "R11 read after stall");
    rd(1, "R11 second read");

    repeat (6) @(posedge clk);
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule